// File: doc/BRIEF.md
# Frame Counter Synchronisation Controller

This block stamps every receive sample frame with a free-running 32-bit unsigned sample counter and keeps that counter identical on two boards that run from one shared clock. The counter travels in-band: in counting mode the first complex channel of each output frame is replaced by the counter, with its upper half in the I word and its lower half in the Q word. The other channels pass through unchanged, one cycle after the input.

A small control register chooses how the board takes part in synchronisation. It can be the board that drives the sync line, the board that listens to it, or a board that neither drives nor listens. On the driving board, a software sync request produces a one-cycle pulse on bit 15 of a shared I/O connector. The listening board sees that pulse through a two-flop synchroniser and an edge detector. The driving board sends its own pulse through an identical delay, so both boards act on the same clock edge. On that edge each board clears its counter and raises a one-cycle reset to the downstream phase accumulators and sample buffers. While the receive stream is stopped, the path is held in reset and sync requests are dropped.

Two build parameters can remove the multi-board logic and the counter stamping. With both removed, the datapath is a plain one-cycle register of the input frames.

Top module: `frame_sync_ctrl`

## Requirements
- R1: During and after synchronous reset: out_valid=0, io_out=0, io_oe=0, cfg_rdata=0 and ds_rst=1.
- R2: The control word has four fields: bit 0 sync request, bit 1 drive enable, bit 2 listen enable, bit 3 counting enable. cfg_rdata returns the stored word. Bit 0 reads 1 for exactly one cycle after it is written and then clears itself.
- R3: Output frames appear one cycle after in_valid frames. With counting enabled, channel 0 carries I = counter[31:16] and Q = counter[15:0]. With counting disabled, channel 0 passes through. Every other channel always passes through unchanged.
- R4: The counter advances by one for each emitted frame. It holds during cycles without in_valid.
- R5: In drive mode, io_oe = 0x8000 (only bit 15). A sync request written at edge E0 drives io_out[15] high for exactly the one cycle after edge E1.
- R6: Three edges after the pulse rises (edge E4), the driving board and a listening board wired to its io_out both assert ds_rst for one cycle on the same edge, with out_valid=0. The next frame carries count 0 on both boards, and the boards then carry equal counts.
- R7: While rx_run=0: ds_rst=1, out_valid=0, the counter is held at 0, and a sync request is not stored and produces no pulse.
- R8: In listen mode, a rising edge on io_in[15] causes exactly one ds_rst pulse, however long the line stays high. In the mode with neither enable set, io_in is ignored and io_oe=0.
- R9: Built with MULTI_EN=0 and COUNT_EN=0, the block never drives io_oe, and its output frames equal its input frames delayed by one cycle.
- R10: When both drive and listen enables are set, drive mode takes priority (io_oe = 0x8000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared sample clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_run | input | 1 | Receive stream running; low holds the path in reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 4 | Control word to write |
| cfg_rdata | output | 4 | Stored control word |
| in_valid | input | 1 | Input frame valid |
| in_i | input | NCH*DW | Input I words, channel 0 in the low slice |
| in_q | input | NCH*DW | Input Q words, channel 0 in the low slice |
| out_valid | output | 1 | Output frame valid |
| out_i | output | NCH*DW | Output I words |
| out_q | output | NCH*DW | Output Q words |
| io_in | input | IO_W | Connector inputs; bit SYNC_BIT is the sync line |
| io_out | output | IO_W | Connector outputs; sync pulse on bit SYNC_BIT |
| io_oe | output | IO_W | Connector output enables |
| ds_rst | output | 1 | Reset to downstream accumulators and buffers |

## Verification
The bench builds two instances with the defaults (NCH=2, DW=16, IO_W=16, SYNC_BIT=15, both features on). The listening instance takes its io_in directly from the driving instance's io_out, so the lockstep edge and equal counts can be observed at the ports. A third instance uses MULTI_EN=0 and COUNT_EN=0 and receives the same frames and control writes, which makes the plain passthrough and the permanently released connector checkable. With DW=16 the counter is 32 bits, so counter wrap is beyond the run length; the bench covers counts near zero, gaps in in_valid, and the reset and hold paths.

// File: rtl/fsync_pkg.sv
package fsync_pkg;
  typedef enum logic [1:0] {
    MODE_ALONE  = 2'd0,
    MODE_DRIVE  = 2'd1,
    MODE_LISTEN = 2'd2
  } sync_mode_e;

  localparam int CTL_W   = 4;
  localparam int BIT_REQ = 0;
  localparam int BIT_DRV = 1;
  localparam int BIT_LSN = 2;
  localparam int BIT_CNT = 3;
endpackage

// File: rtl/fsync_ctl_reg.sv
module fsync_ctl_reg
  import fsync_pkg::*;
#(
  parameter bit MULTI_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_run,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  output logic [CTL_W-1:0] rd_data,
  output sync_mode_e       mode,
  output logic             count_on,
  output logic             pulse
);
  logic [CTL_W-1:0] ctl_q;
  logic             req_d;
  logic             pulse_q;

  always_comb begin
    if (!MULTI_EN)           mode = MODE_ALONE;
    else if (ctl_q[BIT_DRV]) mode = MODE_DRIVE;
    else if (ctl_q[BIT_LSN]) mode = MODE_LISTEN;
    else                     mode = MODE_ALONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q   <= '0;
      req_d   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      req_d   <= ctl_q[BIT_REQ];
      pulse_q <= ctl_q[BIT_REQ] & ~req_d & (mode == MODE_DRIVE);
      if (wr_en) begin
        ctl_q          <= wr_data;
        ctl_q[BIT_REQ] <= wr_data[BIT_REQ] & rx_run;
      end else begin
        ctl_q[BIT_REQ] <= 1'b0;
      end
    end
  end

  assign rd_data  = ctl_q;
  assign count_on = ctl_q[BIT_CNT];
  assign pulse    = pulse_q;

  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_q |=> !pulse_q);

  // R7
  idle_req_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_run |=> !ctl_q[BIT_REQ]);
endmodule

// File: rtl/fsync_evt_pipe.sv
module fsync_evt_pipe #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic src,
  output logic evt
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], src};
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign evt = sync_q[SYNC_STAGES-1] & ~last_q;

  // R8
  one_evt_chk: assert property (@(posedge clk) disable iff (rst)
    evt |=> !evt);
endmodule

// File: rtl/fsync_stamp.sv
module fsync_stamp #(
  parameter int NCH      = 2,
  parameter int DW       = 16,
  parameter bit COUNT_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_run,
  input  logic              evt,
  input  logic              count_on,
  input  logic              in_valid,
  input  logic [NCH*DW-1:0] in_i,
  input  logic [NCH*DW-1:0] in_q,
  output logic              out_valid,
  output logic [NCH*DW-1:0] out_i,
  output logic [NCH*DW-1:0] out_q,
  output logic              ds_rst
);
  localparam int CNT_W = 2 * DW;

  logic [CNT_W-1:0]  cnt_q;
  logic [NCH*DW-1:0] nxt_i, nxt_q;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    if (ch == 0 && COUNT_EN) begin : g_stamp
      assign nxt_i[DW-1:0] = count_on ? cnt_q[CNT_W-1:DW] : in_i[DW-1:0];
      assign nxt_q[DW-1:0] = count_on ? cnt_q[DW-1:0]     : in_q[DW-1:0];
    end else begin : g_pass
      assign nxt_i[ch*DW +: DW] = in_i[ch*DW +: DW];
      assign nxt_q[ch*DW +: DW] = in_q[ch*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !rx_run || evt) begin
      cnt_q     <= '0;
      out_valid <= 1'b0;
      ds_rst    <= 1'b1;
    end else begin
      ds_rst    <= 1'b0;
      out_valid <= in_valid;
      if (in_valid) begin
        out_i <= nxt_i;
        out_q <= nxt_q;
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_run && !evt && in_valid) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  // R4
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_run && !evt && !in_valid) |=> $stable(cnt_q));

  // R6
  evt_clear_chk: assert property (@(posedge clk) disable iff (rst)
    evt |=> (ds_rst && !out_valid && cnt_q == '0));

  // R7
  halt_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_run |=> (ds_rst && !out_valid));
endmodule

// File: rtl/frame_sync_ctrl.sv
module frame_sync_ctrl
  import fsync_pkg::*;
#(
  parameter int NCH      = 2,
  parameter int DW       = 16,
  parameter int IO_W     = 16,
  parameter int SYNC_BIT = 15,
  parameter bit MULTI_EN = 1'b1,
  parameter bit COUNT_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_run,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_wdata,
  output logic [3:0]        cfg_rdata,
  input  logic              in_valid,
  input  logic [NCH*DW-1:0] in_i,
  input  logic [NCH*DW-1:0] in_q,
  output logic              out_valid,
  output logic [NCH*DW-1:0] out_i,
  output logic [NCH*DW-1:0] out_q,
  input  logic [IO_W-1:0]   io_in,
  output logic [IO_W-1:0]   io_out,
  output logic [IO_W-1:0]   io_oe,
  output logic              ds_rst
);
  localparam logic [IO_W-1:0] SYNC_MASK = IO_W'(1) << SYNC_BIT;

  sync_mode_e mode;
  logic       count_on, pulse, evt_src, evt;

  fsync_ctl_reg #(.MULTI_EN(MULTI_EN)) ctl_i (
    .clk(clk), .rst(rst), .rx_run(rx_run),
    .wr_en(cfg_we), .wr_data(cfg_wdata), .rd_data(cfg_rdata),
    .mode(mode), .count_on(count_on), .pulse(pulse)
  );

  always_comb begin
    case (mode)
      MODE_DRIVE:  evt_src = pulse;
      MODE_LISTEN: evt_src = io_in[SYNC_BIT];
      default:     evt_src = 1'b0;
    endcase
  end

  fsync_evt_pipe #(.SYNC_STAGES(2)) evt_i (
    .clk(clk), .rst(rst), .src(evt_src), .evt(evt)
  );

  fsync_stamp #(.NCH(NCH), .DW(DW), .COUNT_EN(COUNT_EN)) stamp_i (
    .clk(clk), .rst(rst), .rx_run(rx_run), .evt(evt), .count_on(count_on),
    .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q), .ds_rst(ds_rst)
  );

  assign io_out = pulse ? SYNC_MASK : '0;
  assign io_oe  = (mode == MODE_DRIVE) ? SYNC_MASK : '0;

  // R5
  oe_pin_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(io_oe));

  // R10
  drive_prio_chk: assert property (@(posedge clk) disable iff (rst)
    (MULTI_EN && cfg_rdata[BIT_DRV] && cfg_rdata[BIT_LSN]) |-> (io_oe == SYNC_MASK));
endmodule

// File: tb/frame_sync_ctrl_tb_top.sv
`timescale 1ns/1ps
module frame_sync_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_run = 1'b0;
  logic        m_we = 1'b0, s_we = 1'b0;
  logic [3:0]  m_wd = '0, s_wd = '0;
  logic        in_valid = 1'b0;
  logic [31:0] in_i = '0, in_q = '0;
  logic [15:0] tb_io = '0;

  logic        m_ov, s_ov, p_ov, m_ds, s_ds, p_ds;
  logic [31:0] m_oi, m_oq, s_oi, s_oq, p_oi, p_oq;
  logic [15:0] m_io, m_oe, s_io, s_oe, p_io, p_oe;
  logic [3:0]  m_rd, s_rd, p_rd;

  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  frame_sync_ctrl dut_i (
    .clk(clk), .rst(rst), .rx_run(rx_run), .cfg_we(m_we), .cfg_wdata(m_wd),
    .cfg_rdata(m_rd), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .out_valid(m_ov), .out_i(m_oi), .out_q(m_oq), .io_in(tb_io),
    .io_out(m_io), .io_oe(m_oe), .ds_rst(m_ds));

  frame_sync_ctrl slave_i (
    .clk(clk), .rst(rst), .rx_run(rx_run), .cfg_we(s_we), .cfg_wdata(s_wd),
    .cfg_rdata(s_rd), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .out_valid(s_ov), .out_i(s_oi), .out_q(s_oq), .io_in(m_io),
    .io_out(s_io), .io_oe(s_oe), .ds_rst(s_ds));

  frame_sync_ctrl #(.MULTI_EN(1'b0), .COUNT_EN(1'b0)) plain_i (
    .clk(clk), .rst(rst), .rx_run(rx_run), .cfg_we(m_we), .cfg_wdata(m_wd),
    .cfg_rdata(p_rd), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .out_valid(p_ov), .out_i(p_oi), .out_q(p_oq), .io_in(tb_io),
    .io_out(p_io), .io_oe(p_oe), .ds_rst(p_ds));

  // valid | i0 | q0 | i1 | q1
  localparam logic [64:0] VEC [8] = '{
    65'h1_AAAA_BBBB_1111_2222,
    65'h1_0123_4567_89AB_CDEF,
    65'h0_FFFF_FFFF_DEAD_BEEF,
    65'h1_5555_6666_7777_8888,
    65'h0_0000_0000_0000_0000,
    65'h0_1212_3434_5656_7878,
    65'h1_FFFF_0000_0000_FFFF,
    65'h1_0F0F_F0F0_A5A5_5A5A
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_m(input logic [3:0] d);
    @(negedge clk); m_we = 1'b1; m_wd = d;
    @(negedge clk); m_we = 1'b0;
  endtask

  task automatic wr_s(input logic [3:0] d);
    @(negedge clk); s_we = 1'b1; s_wd = d;
    @(negedge clk); s_we = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int exp_cnt;
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 out_valid", m_ov, 0);
    chk("R1 io_out", m_io, 0);
    chk("R1 io_oe", m_oe, 0);
    chk("R1 cfg_rdata", m_rd, 0);
    chk("R1 ds_rst", m_ds, 1);
    rst = 1'b0;

    rx_run = 1'b1; in_valid = 1'b1; in_i = 32'h9999_1111; in_q = 32'h8888_2222;
    wr_s(4'b1100);
    wr_m(4'b1010);
    chk("R2 readback", m_rd, 4'hA);
    chk("R5 drive oe", m_oe, 16'h8000);

    // R5 / R6 sync sequence, write lands at E0
    wr_m(4'b1011);
    chk("R2 req set", m_rd, 4'hB);
    @(negedge clk);                                  // after E1
    chk("R5 pulse high", m_io, 16'h8000);
    chk("R2 req self-clear", m_rd, 4'hA);
    @(negedge clk);                                  // after E2
    chk("R5 pulse one cycle", m_io, 0);
    @(negedge clk);                                  // after E3
    chk("R6 no early reset", {m_ds, s_ds}, 0);
    @(negedge clk);                                  // after E4
    chk("R6 drive ds_rst", m_ds, 1);
    chk("R6 listen ds_rst same edge", s_ds, 1);
    chk("R6 out_valid low", {m_ov, s_ov}, 0);
    @(negedge clk);                                  // after E5
    chk("R6 drive ds_rst released", m_ds, 0);
    chk("R6 drive first count", {m_oi[15:0], m_oq[15:0]}, 0);
    chk("R6 listen first count", {s_oi[15:0], s_oq[15:0]}, 0);
    @(negedge clk);                                  // after E6
    chk("R4 second count", {m_oi[15:0], m_oq[15:0]}, 1);

    // R3 / R4 / R9 vector walk
    exp_cnt = 2;
    for (int k = 0; k < 8; k++) begin
      in_valid = VEC[k][64];
      in_i = {VEC[k][31:16], VEC[k][63:48]};
      in_q = {VEC[k][15:0],  VEC[k][47:32]};
      @(negedge clk);
      chk("R4 out_valid", m_ov, VEC[k][64]);
      chk("R9 plain valid", p_ov, VEC[k][64]);
      if (VEC[k][64]) begin
        chk("R3 ch0 count", {m_oi[15:0], m_oq[15:0]}, exp_cnt);
        chk("R3 ch1 pass", {m_oi[31:16], m_oq[31:16]}, VEC[k][31:0]);
        chk("R6 lockstep", {s_oi[15:0], s_oq[15:0]}, {m_oi[15:0], m_oq[15:0]});
        chk("R9 plain data", {p_oi, p_oq}, {in_i, in_q});
        exp_cnt++;
      end
    end
    in_valid = 1'b0;

    // R3 counting disabled
    wr_m(4'b0010);
    in_valid = 1'b1; in_i = 32'h4321_1234; in_q = 32'h8765_5678;
    @(negedge clk);
    chk("R3 ch0 pass when counting off", {m_oi, m_oq}, {in_i, in_q});
    in_valid = 1'b0;

    // R7 stream stopped
    rx_run = 1'b0; in_valid = 1'b1;
    wr_m(4'b1011);
    chk("R7 request dropped", m_rd, 4'hA);
    n = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (m_io != 0) n++;
      chk("R7 held reset", {m_ds, m_ov}, 2'b10);
    end
    chk("R7 no pulse", n, 0);
    rx_run = 1'b1; in_valid = 1'b0;

    // R8 listen mode, long level
    wr_m(4'b1100);
    repeat (4) @(negedge clk);
    tb_io = 16'h8000;
    n = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (m_ds) n++;
    end
    chk("R8 one reset per level", n, 1);
    tb_io = '0;
    repeat (4) @(negedge clk);

    // R8 neither enable set
    wr_m(4'b1000);
    repeat (3) @(negedge clk);
    n = 0;
    for (int k = 0; k < 10; k++) begin
      tb_io = (k % 2 == 0) ? 16'h8000 : 16'h0000;
      @(negedge clk);
      if (m_ds) n++;
    end
    tb_io = '0;
    repeat (4) begin @(negedge clk); if (m_ds) n++; end
    chk("R8 alone ignores io_in", n, 0);
    chk("R8 alone oe", m_oe, 0);

    // R10 priority
    wr_m(4'b1110);
    chk("R10 drive wins", m_oe, 16'h8000);
    // R9 plain build never drives the connector
    chk("R9 plain oe", p_oe, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule